// File: doc/BRIEF.md
# Inter-Core Doorbell Mailbox Bank

This block holds sixteen 32-bit doorbell words, four owned by each of four cores, and lets cores signal each other. No word is ever written directly. A sender ORs bits into a word through that word's set address. The receiver removes bits through the matching clear address. Each word drives one interrupt level toward its owning core. The level stays high for as long as any bit of the word is nonzero.

Software reaches the bank through two identical access ports. Each port carries one read or write per cycle. Because there are two ports, a set and a clear, or two sets, can reach the same word in the same cycle, and both updates are merged. The ports have no back-pressure: a request presented with its valid bit high is always accepted in that cycle. Each read returns one cycle later, on a response that is marked valid. The 16-bit interrupt vector goes to an external router, which handles enables and the choice between normal and fast interrupt.

Top module: `doorbell_mbox_top`

## Requirements
- R1: After reset every word reads as zero, the interrupt vector is zero and both response-valid outputs are low.
- R2: Word index k equals 4*core + slot, where core is 0..3 and slot is 0..3. Its set address is 0x80 + 4*k and its clear address is 0xC0 + 4*k. Address bits [1:0] are ignored, so the set window is 0x80-0xBF and the clear window is 0xC0-0xFF.
- R3: A write to a set address ORs the write data into the word.
- R4: A write to a clear address zeroes every bit of the word that is 1 in the write data and leaves the other bits unchanged.
- R5: Bit k of `mbox_irq` is 1 exactly when word k is nonzero. It changes at the first clock edge after the write that changes the word.
- R6: If a set and a clear reach the same word in one cycle, the result is (old & ~clear_data) | set_data. A bit that is 1 in both keeps its value of 1.
- R7: Two sets to the same word in one cycle OR together. Two clears to the same word in one cycle both take effect.
- R8: A read of a clear address raises `rd_valid` for that port one cycle later, with `rd_data` equal to the word's value before any write made in the same cycle.
- R9: A read of a set address, or of an address outside 0x80-0xFF, returns zero with `rd_valid` high. A write outside 0x80-0xFF changes no word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| acc_valid | input | 2 | Request valid, one bit per port (always accepted) |
| acc_write | input | 2 | 1 = write, 0 = read, one bit per port |
| acc_addr | input | 16 | Byte address, 8 bits per port, port p at [8p+7:8p] |
| acc_wdata | input | 64 | Write data, 32 bits per port |
| rd_valid | output | 2 | Read response valid, one cycle after a read |
| rd_data | output | 64 | Read response data, 32 bits per port |
| mbox_irq | output | 16 | Interrupt level per word, bit k = word k |

## Verification
The bench aims at merged updates. It sends a set and an overlapping clear to one word in the same cycle. A design that let the clear win would lose the shared bits. It also sends paired sets and paired clears, where a design that kept only one port's write would drop half of the data. A read that coincides with a write to the same word must return the old value, so a design that forwarded the new value fails. The bench also checks that reads of set addresses return zero, that out-of-window writes change nothing, and that the interrupt rises exactly one edge after the write, which catches a missing register or an extra one.

// File: rtl/mbox_pkg.sv
`timescale 1ns/1ps
package mbox_pkg;
  // Which address window a request falls into.
  typedef enum logic [1:0] {
    WIN_NONE = 2'd0,
    WIN_SET  = 2'd1,
    WIN_CLR  = 2'd2
  } win_e;
endpackage

// File: rtl/mbox_addr_decode.sv
`timescale 1ns/1ps
module mbox_addr_decode
  import mbox_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int NUM_MBOX = 16,
  parameter logic [ADDR_W-1:0] SET_BASE = 8'h80,
  parameter logic [ADDR_W-1:0] CLR_BASE = 8'hC0,
  localparam int IDX_W = $clog2(NUM_MBOX)
) (
  input  logic                       acc_valid,
  input  logic                       acc_write,
  input  logic [ADDR_W-1:0]          acc_addr,
  input  logic [DATA_W-1:0]          acc_wdata,
  output logic [NUM_MBOX*DATA_W-1:0] set_bus,
  output logic [NUM_MBOX*DATA_W-1:0] clr_bus,
  output logic                       rd_en,
  output logic                       rd_is_clr,
  output logic [IDX_W-1:0]           rd_idx
);
  localparam int WIN_BYTES = NUM_MBOX * 4;
  localparam logic [ADDR_W:0] SET_END = {1'b0, SET_BASE} + (ADDR_W+1)'(WIN_BYTES);
  localparam logic [ADDR_W:0] CLR_END = {1'b0, CLR_BASE} + (ADDR_W+1)'(WIN_BYTES);

  win_e             win;
  logic [IDX_W-1:0] idx;
  logic [ADDR_W:0]  a_ext;
  logic             wr_en;

  assign a_ext = {1'b0, acc_addr};
  assign wr_en = acc_valid & acc_write;

  always_comb begin
    win = WIN_NONE;
    idx = '0;
    if (a_ext >= {1'b0, SET_BASE} && a_ext < SET_END) begin
      win = WIN_SET;
      idx = IDX_W'((acc_addr - SET_BASE) >> 2);
    end else if (a_ext >= {1'b0, CLR_BASE} && a_ext < CLR_END) begin
      win = WIN_CLR;
      idx = IDX_W'((acc_addr - CLR_BASE) >> 2);
    end
  end

  for (genvar i = 0; i < NUM_MBOX; i++) begin : g_lane
    assign set_bus[i*DATA_W +: DATA_W] =
      (wr_en && win == WIN_SET && idx == IDX_W'(i)) ? acc_wdata : '0;
    assign clr_bus[i*DATA_W +: DATA_W] =
      (wr_en && win == WIN_CLR && idx == IDX_W'(i)) ? acc_wdata : '0;
  end

  assign rd_en     = acc_valid & ~acc_write;
  assign rd_is_clr = (win == WIN_CLR);
  assign rd_idx    = idx;
endmodule

// File: rtl/mbox_cell.sv
`timescale 1ns/1ps
module mbox_cell #(
  parameter int DATA_W    = 32,
  parameter int NUM_PORTS = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_PORTS*DATA_W-1:0]   set_in,
  input  logic [NUM_PORTS*DATA_W-1:0]   clr_in,
  output logic [DATA_W-1:0]             q,
  output logic                          irq
);
  logic [DATA_W-1:0] set_any, clr_any, nxt;

  always_comb begin
    set_any = '0;
    clr_any = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      set_any = set_any | set_in[p*DATA_W +: DATA_W];
      clr_any = clr_any | clr_in[p*DATA_W +: DATA_W];
    end
    // Set has priority over clear, bit by bit.
    nxt = (q & ~clr_any) | set_any;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q   <= '0;
      irq <= 1'b0;
    end else begin
      q   <= nxt;
      irq <= |nxt;
    end
  end
endmodule

// File: rtl/mbox_read_port.sv
`timescale 1ns/1ps
module mbox_read_port #(
  parameter int DATA_W   = 32,
  parameter int NUM_MBOX = 16,
  localparam int IDX_W = $clog2(NUM_MBOX)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       rd_en,
  input  logic                       rd_is_clr,
  input  logic [IDX_W-1:0]           rd_idx,
  input  logic [NUM_MBOX*DATA_W-1:0] contents,
  output logic                       rd_valid,
  output logic [DATA_W-1:0]          rd_data
);
  logic [DATA_W-1:0] sel;

  always_comb begin
    sel = '0;
    for (int i = 0; i < NUM_MBOX; i++) begin
      if (rd_idx == IDX_W'(i)) sel = contents[i*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      rd_data  <= (rd_en && rd_is_clr) ? sel : '0;
    end
  end
endmodule

// File: rtl/doorbell_mbox_top.sv
`timescale 1ns/1ps
module doorbell_mbox_top #(
  parameter int NUM_CORES     = 4,
  parameter int MBOX_PER_CORE = 4,
  parameter int DATA_W        = 32,
  parameter int ADDR_W        = 8,
  parameter int NUM_PORTS     = 2,
  parameter logic [ADDR_W-1:0] SET_BASE = 8'h80,
  parameter logic [ADDR_W-1:0] CLR_BASE = 8'hC0,
  localparam int NUM_MBOX = NUM_CORES * MBOX_PER_CORE,
  localparam int IDX_W    = $clog2(NUM_MBOX)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_PORTS-1:0]        acc_valid,
  input  logic [NUM_PORTS-1:0]        acc_write,
  input  logic [NUM_PORTS*ADDR_W-1:0] acc_addr,
  input  logic [NUM_PORTS*DATA_W-1:0] acc_wdata,
  output logic [NUM_PORTS-1:0]        rd_valid,
  output logic [NUM_PORTS*DATA_W-1:0] rd_data,
  output logic [NUM_MBOX-1:0]         mbox_irq
);
  logic [NUM_MBOX*DATA_W-1:0] set_bus [NUM_PORTS];
  logic [NUM_MBOX*DATA_W-1:0] clr_bus [NUM_PORTS];
  logic [NUM_PORTS-1:0]       rd_en_w;
  logic [NUM_PORTS-1:0]       rd_clr_w;
  logic [IDX_W-1:0]           rd_idx_w [NUM_PORTS];
  logic [NUM_MBOX*DATA_W-1:0] mbox_q;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    mbox_addr_decode #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_MBOX(NUM_MBOX),
      .SET_BASE(SET_BASE), .CLR_BASE(CLR_BASE)
    ) u_dec (
      .acc_valid (acc_valid[p]),
      .acc_write (acc_write[p]),
      .acc_addr  (acc_addr[p*ADDR_W +: ADDR_W]),
      .acc_wdata (acc_wdata[p*DATA_W +: DATA_W]),
      .set_bus   (set_bus[p]),
      .clr_bus   (clr_bus[p]),
      .rd_en     (rd_en_w[p]),
      .rd_is_clr (rd_clr_w[p]),
      .rd_idx    (rd_idx_w[p])
    );

    mbox_read_port #(.DATA_W(DATA_W), .NUM_MBOX(NUM_MBOX)) u_rd (
      .clk       (clk),
      .rst       (rst),
      .rd_en     (rd_en_w[p]),
      .rd_is_clr (rd_clr_w[p]),
      .rd_idx    (rd_idx_w[p]),
      .contents  (mbox_q),
      .rd_valid  (rd_valid[p]),
      .rd_data   (rd_data[p*DATA_W +: DATA_W])
    );
  end

  for (genvar i = 0; i < NUM_MBOX; i++) begin : g_mbox
    logic [NUM_PORTS*DATA_W-1:0] set_g, clr_g;
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_gather
      assign set_g[p*DATA_W +: DATA_W] = set_bus[p][i*DATA_W +: DATA_W];
      assign clr_g[p*DATA_W +: DATA_W] = clr_bus[p][i*DATA_W +: DATA_W];
    end
    mbox_cell #(.DATA_W(DATA_W), .NUM_PORTS(NUM_PORTS)) u_cell (
      .clk    (clk),
      .rst    (rst),
      .set_in (set_g),
      .clr_in (clr_g),
      .q      (mbox_q[i*DATA_W +: DATA_W]),
      .irq    (mbox_irq[i])
    );
  end
endmodule

// File: rtl/mbox_checker.sv
`timescale 1ns/1ps
module mbox_checker #(
  parameter int NUM_MBOX  = 16,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 8,
  parameter int NUM_PORTS = 2,
  parameter logic [ADDR_W-1:0] SET_BASE = 8'h80,
  parameter logic [ADDR_W-1:0] CLR_BASE = 8'hC0,
  localparam int IDX_W = $clog2(NUM_MBOX)
) (
  input logic                        clk,
  input logic                        rst,
  input logic [NUM_PORTS-1:0]        acc_valid,
  input logic [NUM_PORTS-1:0]        acc_write,
  input logic [NUM_PORTS*ADDR_W-1:0] acc_addr,
  input logic [NUM_PORTS*DATA_W-1:0] acc_wdata,
  input logic [NUM_PORTS-1:0]        rd_valid,
  input logic [NUM_PORTS*DATA_W-1:0] rd_data,
  input logic [NUM_MBOX-1:0]         mbox_irq,
  input logic [NUM_MBOX*DATA_W-1:0]  contents
);
  localparam int SPAN = NUM_MBOX * 4;

  logic [NUM_MBOX-1:0]  set_hit [NUM_PORTS];
  logic [NUM_MBOX-1:0]  clr_hit [NUM_PORTS];
  logic [NUM_PORTS-1:0] in_set_win;
  logic [NUM_MBOX-1:0]  any_hit;

  always_comb begin
    any_hit = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      int a, so, co;
      a  = int'(acc_addr[p*ADDR_W +: ADDR_W]);
      so = a - int'(SET_BASE);
      co = a - int'(CLR_BASE);
      in_set_win[p] = (so >= 0) && (so < SPAN);
      for (int i = 0; i < NUM_MBOX; i++) begin
        set_hit[p][i] = acc_valid[p] && acc_write[p] && in_set_win[p] && (so / 4 == i);
        clr_hit[p][i] = acc_valid[p] && acc_write[p] && (co >= 0) && (co < SPAN) && (co / 4 == i);
        any_hit[i]    = any_hit[i] | set_hit[p][i] | clr_hit[p][i];
      end
    end
  end

  for (genvar i = 0; i < NUM_MBOX; i++) begin : g_m
    assert_irq_level_R5: assert property (@(posedge clk) disable iff (rst)
      mbox_irq[i] == (|contents[i*DATA_W +: DATA_W]));

    assert_untouched_stable_R9: assert property (@(posedge clk) disable iff (rst)
      !any_hit[i] |=> $stable(contents[i*DATA_W +: DATA_W]));

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_p
      // Set bits must be present afterwards, even against a clear (R6).
      assert_set_bits_land_R3: assert property (@(posedge clk) disable iff (rst)
        set_hit[p][i] |=> ((contents[i*DATA_W +: DATA_W] & $past(acc_wdata[p*DATA_W +: DATA_W]))
                           == $past(acc_wdata[p*DATA_W +: DATA_W])));
    end
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_rd
    assert_read_response_R8: assert property (@(posedge clk) disable iff (rst)
      (acc_valid[p] && !acc_write[p]) |=> rd_valid[p]);
    assert_no_spurious_response_R8: assert property (@(posedge clk) disable iff (rst)
      !(acc_valid[p] && !acc_write[p]) |=> !rd_valid[p]);
    assert_set_window_reads_zero_R9: assert property (@(posedge clk) disable iff (rst)
      (acc_valid[p] && !acc_write[p] && in_set_win[p]) |=> rd_data[p*DATA_W +: DATA_W] == '0);
  end
endmodule

bind doorbell_mbox_top mbox_checker #(
  .NUM_MBOX(NUM_MBOX), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_PORTS(NUM_PORTS),
  .SET_BASE(SET_BASE), .CLR_BASE(CLR_BASE)
) u_chk (
  .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
  .acc_addr(acc_addr), .acc_wdata(acc_wdata), .rd_valid(rd_valid),
  .rd_data(rd_data), .mbox_irq(mbox_irq), .contents(mbox_q)
);

// File: tb/sim_doorbell_mbox_top.sv
`timescale 1ns/1ps
module sim_doorbell_mbox_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  acc_valid = '0, acc_write = '0;
  logic [15:0] acc_addr = '0;
  logic [63:0] acc_wdata = '0;
  logic [1:0]  rd_valid;
  logic [63:0] rd_data;
  logic [15:0] mbox_irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  doorbell_mbox_top u0 (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .rd_valid(rd_valid),
    .rd_data(rd_data), .mbox_irq(mbox_irq)
  );

  typedef struct packed {
    logic v0; logic w0; logic [7:0] a0; logic [31:0] d0;
    logic v1; logic w1; logic [7:0] a1; logic [31:0] d1;
    logic [3:0] chk; logic [31:0] exp;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{1'b1,1'b1,8'h80,32'h0000_00F0, 1'b0,1'b0,8'h00,32'h0,         4'd0, 32'h0000_00F0}, // R3
    '{1'b1,1'b1,8'h80,32'h0000_000F, 1'b0,1'b0,8'h00,32'h0,         4'd0, 32'h0000_00FF}, // R3
    '{1'b1,1'b1,8'hC0,32'h0000_003C, 1'b0,1'b0,8'h00,32'h0,         4'd0, 32'h0000_00C3}, // R4
    '{1'b1,1'b1,8'h9C,32'hA5A5_0000, 1'b0,1'b0,8'h00,32'h0,         4'd7, 32'hA5A5_0000}, // R2
    '{1'b1,1'b1,8'hBF,32'h0000_0001, 1'b0,1'b0,8'h00,32'h0,         4'd15,32'h0000_0001}, // R2
    '{1'b1,1'b1,8'h84,32'h0000_00FF, 1'b0,1'b0,8'h00,32'h0,         4'd1, 32'h0000_00FF}, // R3
    '{1'b1,1'b1,8'h84,32'h0000_FF00, 1'b1,1'b1,8'hC4,32'h0000_0FF0, 4'd1, 32'h0000_FF0F}, // R6
    '{1'b1,1'b1,8'hA4,32'h0000_0011, 1'b1,1'b1,8'hA4,32'h0000_1100, 4'd9, 32'h0000_1111}, // R7
    '{1'b1,1'b1,8'hE4,32'h0000_0001, 1'b1,1'b1,8'hE4,32'h0000_1000, 4'd9, 32'h0000_0110}, // R7
    '{1'b1,1'b1,8'h40,32'hFFFF_FFFF, 1'b0,1'b0,8'h00,32'h0,         4'd0, 32'h0000_00C3}, // R9
    '{1'b0,1'b0,8'h00,32'h0,         1'b1,1'b1,8'hC0,32'hFFFF_FFFF, 4'd0, 32'h0000_0000}  // R4
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic v0, w0, input logic [7:0] a0, input logic [31:0] d0,
                       input logic v1, w1, input logic [7:0] a1, input logic [31:0] d1);
    @(negedge clk);
    acc_valid = {v1, v0};
    acc_write = {w1, w0};
    acc_addr  = {a1, a0};
    acc_wdata = {d1, d0};
  endtask

  task automatic idle();
    drive(1'b0,1'b0,8'h00,32'h0, 1'b0,1'b0,8'h00,32'h0);
  endtask

  // Read on port 0, then sample the response at the following negedge.
  task automatic read0(input logic [7:0] a, output logic [31:0] d, output logic v);
    drive(1'b1,1'b0,a,32'h0, 1'b0,1'b0,8'h00,32'h0);
    idle();
    d = rd_data[31:0];
    v = rd_valid[0];
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check("R1 irq after reset", {16'h0, mbox_irq}, 32'h0);
    check("R1 rd_valid idle", {30'h0, rd_valid}, 32'h0);
    read0(8'hC0, d, v);
    check("R1 word0 after reset", d, 32'h0);

    // Table walk: R2 R3 R4 R6 R7 R9
    for (int k = 0; k < NV; k++) begin
      drive(VECS[k].v0, VECS[k].w0, VECS[k].a0, VECS[k].d0,
            VECS[k].v1, VECS[k].w1, VECS[k].a1, VECS[k].d1);
      read0(8'hC0 + {2'b00, VECS[k].chk, 2'b00}, d, v);
      check($sformatf("R3 R4 R6 R7 table vector %0d data", k), d, VECS[k].exp);
      check($sformatf("R5 table vector %0d irq", k),
            {31'h0, mbox_irq[VECS[k].chk]}, {31'h0, VECS[k].exp != 0});
    end

    // R8: read and write to the same word in one cycle returns the old value.
    drive(1'b1,1'b0,8'hE4,32'h0, 1'b1,1'b1,8'hA4,32'h0000_8000);
    idle();
    check("R8 read during write old value", rd_data[31:0], 32'h0000_0110);
    check("R8 rd_valid", {31'h0, rd_valid[0]}, 32'h1);
    read0(8'hE4, d, v);
    check("R8 read after write", d, 32'h0000_8110);

    // R9: set-window read and outside read return zero with valid.
    read0(8'h9C, d, v);
    check("R9 set address read", d, 32'h0);
    check("R9 set address read valid", {31'h0, v}, 32'h1);
    read0(8'h20, d, v);
    check("R9 outside read", d, 32'h0);

    // R5: interrupt rises and falls exactly one edge after the write.
    drive(1'b1,1'b1,8'h8C,32'h4, 1'b0,1'b0,8'h00,32'h0);
    check("R5 irq before edge", {31'h0, mbox_irq[3]}, 32'h0);
    idle();
    check("R5 irq after one edge", {31'h0, mbox_irq[3]}, 32'h1);
    drive(1'b1,1'b1,8'hCC,32'h4, 1'b0,1'b0,8'h00,32'h0);
    check("R5 irq held before clear edge", {31'h0, mbox_irq[3]}, 32'h1);
    idle();
    check("R5 irq drops after clear", {31'h0, mbox_irq[3]}, 32'h0);

    // R2: core 2 slot 0 lives at 0xA0 and drives irq bit 8.
    drive(1'b0,1'b0,8'h00,32'h0, 1'b1,1'b1,8'hA0,32'h2);
    idle();
    check("R2 core2 slot0 irq bit", {16'h0, mbox_irq}, 32'h0000_8382);
    read0(8'hE0, d, v);
    check("R2 core2 slot0 contents", d, 32'h2);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule